// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a four-bank SDRAM with a 48-bit data path. It takes the memory from power-on to a ready state. While reset is held, meaning supply power is not yet stable, it keeps the clock enable, chip select and byte masks low. After reset is released it raises the clock enable and every byte mask. It then places a no-operation code on the command bus for a settling period whose length is set by a parameter.

When the settling period ends, the sequencer issues the following commands in a fixed order:

1. A precharge of every bank.
2. After the row-precharge time, a burst of auto-refresh commands. The burst length is set by a parameter and is never fewer than eight.
3. A mode-register load carrying a 12-bit mode word taken from an input port.

After the mode-register settling time, a ready flag rises and stays high. Because the byte masks stay high for the whole sequence, the memory keeps its data pins in high impedance. Several devices can therefore share one data bus during start-up without contention. Pulling the synchronous reset low at any time aborts the sequence, and the next release starts again from the settling wait.

Top module: `sdinit_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, from the next cycle on `cke`, `cs_n`, every `dqm` bit and `init_done` are all 0.
- R2: In every cycle after the first rising clock edge with `rst_n` high, and until reset is asserted again, `cke` is 1 and all `dqm` bits are 1.
- R3: The first command is a precharge-all, encoded as `cs_n`=0, `ras_n`=0, `cas_n`=1, `we_n`=0 with address bit 10 high. It appears exactly STARTUP_CYC cycles after the first cycle with `cke` high, and no command appears before it.
- R4: The first auto-refresh appears exactly TRP_CYC cycles after the precharge-all. An auto-refresh is encoded as `cs_n`=0, `ras_n`=0, `cas_n`=0, `we_n`=1.
- R5: The sequencer issues exactly max(REF_COUNT, 8) auto-refresh commands, consecutive ones spaced TRC_CYC cycles apart.
- R6: A single mode-register load, encoded with all four command pins 0, appears TRC_CYC cycles after the last refresh. During it `addr` equals `mode_word` zero-extended and `ba` is 0.
- R7: `init_done` rises exactly TMRD_CYC cycles after the mode-register load and stays 1 until reset.
- R8: Every cycle with `cke` high that carries none of the three commands carries a no-operation: `cs_n`=0 with `ras_n`, `cas_n` and `we_n` all 1.
- R9: Asserting reset at any point of the sequence and releasing it restarts the whole sequence with the timing of R3 to R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low; low means power not yet stable |
| mode_word | input | 12 | Value written to the memory's mode register |
| cke | output | 1 | Memory clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W (12) | Memory address lines |
| ba | output | BA_W (2) | Bank select lines |
| dqm | output | DATA_W/8 (6) | Byte masks, one per data byte |
| init_done | output | 1 | Initialization complete; stays high until reset |

## Verification
The assertions assume that `rst_n` changes only away from the rising clock edge. They also assume that `mode_word` is stable whenever a mode-register load is on the bus, since the address lines follow it combinationally. The bench changes reset and the mode word only on falling edges, and only between runs. It draws a random mode word for each run, and half of the runs are cut short by a reset at a random cycle. Directed runs cover the all-zeros and all-ones mode words and a reset during the refresh burst.

// File: rtl/sdinit_pkg.sv
// Package: shared state encoding and command pin codes for the SDRAM
// power-up sequencer. Assumes the usual active-low SDRAM command pins.
package sdinit_pkg;

    typedef enum logic [3:0] {
        ST_OFF,     // reset held: power not stable
        ST_SETTLE,  // startup wait, NOP on the bus
        ST_PALL,    // precharge all banks
        ST_TRP,     // row precharge wait
        ST_REF,     // auto-refresh
        ST_TRC,     // refresh cycle wait
        ST_MRS,     // mode register load
        ST_TMRD,    // mode register settle wait
        ST_DONE     // ready, NOP forever
    } seq_state_t;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

    localparam cmd_pins_t PINS_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam cmd_pins_t PINS_PALL = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam cmd_pins_t PINS_REF  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
    localparam cmd_pins_t PINS_MRS  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
    localparam cmd_pins_t PINS_OFF  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

    // Larger of two integers, used to clamp timing parameters.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdinit_count.sv
// Module: loadable down counter used for wait windows and the refresh tally.
// Assumes load has priority over decrement; the count holds once it is zero.
module sdinit_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] value,
    output logic         zero
);

    logic [W-1:0] cnt;

    // Count register: clear on reset, load on request, else step toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec && (cnt != '0)) begin
            cnt <= cnt - W'(1);
        end
    end

    // Outputs: the current count and its zero flag.
    always_comb begin
        value = cnt;
        zero  = (cnt == '0);
    end

endmodule

// File: rtl/sdinit_ctrl.sv
// Module: phase controller of the power-up sequence. It steps through
// settle, precharge-all, the refresh burst and the mode load, timing each gap
// with one counter and tallying refreshes with another.
// Assumes: STARTUP >= 1, the other gaps >= 2, and at least 8 refreshes
// (smaller values are clamped).
module sdinit_ctrl
    import sdinit_pkg::*;
#(
    parameter int STARTUP_CYC = 200,
    parameter int TRP_CYC     = 3,
    parameter int TRC_CYC     = 9,
    parameter int TMRD_CYC    = 2,
    parameter int REF_COUNT   = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    output seq_state_t state
);

    localparam int STARTUP_EFF = imax(STARTUP_CYC, 1);
    localparam int TRP_EFF     = imax(TRP_CYC, 2);
    localparam int TRC_EFF     = imax(TRC_CYC, 2);
    localparam int TMRD_EFF    = imax(TMRD_CYC, 2);
    localparam int REF_EFF     = imax(REF_COUNT, 8);
    localparam int GAP_MAX     = imax(imax(STARTUP_EFF, TRP_EFF), imax(TRC_EFF, TMRD_EFF));
    localparam int TW          = $clog2(GAP_MAX + 1) + 1;
    localparam int RW          = $clog2(REF_EFF + 1);

    seq_state_t    nxt;
    logic          tmr_load;
    logic [TW-1:0] tmr_ld_val;
    logic [TW-1:0] tmr_val;
    logic          tmr_zero;
    logic          ref_load;
    logic          ref_dec;
    logic [RW-1:0] ref_val;
    logic          ref_zero;

    // Gap timer: a wait state loaded with v lasts v+1 cycles.
    sdinit_count #(.W(TW)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_ld_val),
        .dec      (1'b1),
        .value    (tmr_val),
        .zero     (tmr_zero)
    );

    // Refresh tally: number of refreshes still to issue after the current one.
    sdinit_count #(.W(RW)) u_refs (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ref_load),
        .load_val (RW'(REF_EFF - 1)),
        .dec      (ref_dec),
        .value    (ref_val),
        .zero     (ref_zero)
    );

    // Next-phase logic with the counter loads that open each wait window.
    always_comb begin
        nxt        = state;
        tmr_load   = 1'b0;
        tmr_ld_val = '0;
        ref_load   = 1'b0;
        ref_dec    = 1'b0;
        case (state)
            ST_OFF: begin
                nxt        = ST_SETTLE;
                tmr_load   = 1'b1;
                tmr_ld_val = TW'(STARTUP_EFF - 1);
            end
            ST_SETTLE: if (tmr_zero) nxt = ST_PALL;
            ST_PALL: begin
                nxt        = ST_TRP;
                tmr_load   = 1'b1;
                tmr_ld_val = TW'(TRP_EFF - 2);
                ref_load   = 1'b1;
            end
            ST_TRP: if (tmr_zero) nxt = ST_REF;
            ST_REF: begin
                nxt        = ST_TRC;
                tmr_load   = 1'b1;
                tmr_ld_val = TW'(TRC_EFF - 2);
            end
            ST_TRC: begin
                if (tmr_zero) begin
                    if (ref_zero) begin
                        nxt = ST_MRS;
                    end else begin
                        nxt     = ST_REF;
                        ref_dec = 1'b1;
                    end
                end
            end
            ST_MRS: begin
                nxt        = ST_TMRD;
                tmr_load   = 1'b1;
                tmr_ld_val = TW'(TMRD_EFF - 2);
            end
            ST_TMRD: if (tmr_zero) nxt = ST_DONE;
            ST_DONE: nxt = ST_DONE;
            default: nxt = ST_OFF;
        endcase
    end

    // Phase register: reset parks the sequence in the power-off phase.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    // Leaving reset loads the full startup window.
    assert_settle_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |=> (state == ST_SETTLE) && (tmr_val == TW'(STARTUP_EFF - 1)));

    // The precharge opens the row-precharge window.
    assert_trp_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PALL) |=> (state == ST_TRP) && (tmr_val == TW'(TRP_EFF - 2)));

    // The mode load only follows an exhausted refresh tally.
    assert_mrs_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MRS) |-> ref_zero);

    // The refresh tally never exceeds its loaded budget.
    assert_ref_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ref_val <= RW'(REF_EFF - 1));

endmodule

// File: rtl/sdinit_pins.sv
// Module: turns the sequencer phase into SDRAM pin levels. Power-off drives
// enable, select and masks low; all other phases keep enable and masks high.
// Assumes MODE_W <= ADDR_W and AP_BIT < ADDR_W.
module sdinit_pins
    import sdinit_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BA_W   = 2,
    parameter int DQM_W  = 6,
    parameter int MODE_W = 12,
    parameter int AP_BIT = 10
) (
    input  seq_state_t        state,
    input  logic [MODE_W-1:0] mode_word,
    output logic              cke,
    output cmd_pins_t         pins,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba,
    output logic [DQM_W-1:0]  dqm,
    output logic              done
);

    // Pin decode: one command code and address pattern per phase.
    always_comb begin
        cke  = 1'b1;
        dqm  = '1;
        pins = PINS_NOP;
        addr = '0;
        ba   = '0;
        done = 1'b0;
        case (state)
            ST_OFF: begin
                cke  = 1'b0;
                dqm  = '0;
                pins = PINS_OFF;
            end
            ST_PALL: begin
                pins         = PINS_PALL;
                addr[AP_BIT] = 1'b1;
            end
            ST_REF:  pins = PINS_REF;
            ST_MRS: begin
                pins = PINS_MRS;
                addr = ADDR_W'(mode_word);
            end
            ST_DONE: done = 1'b1;
            default: pins = PINS_NOP;
        endcase
    end

endmodule

// File: rtl/sdinit_seq.sv
// Module: top of the SDRAM power-up sequencer. It joins the phase controller
// and the pin decoder. Assumes a single clock and a synchronous active-low
// reset that is released only once power is stable.
module sdinit_seq
    import sdinit_pkg::*;
#(
    parameter int STARTUP_CYC = 200,
    parameter int TRP_CYC     = 3,
    parameter int TRC_CYC     = 9,
    parameter int TMRD_CYC    = 2,
    parameter int REF_COUNT   = 8,
    parameter int ADDR_W      = 12,
    parameter int BA_W        = 2,
    parameter int DATA_W      = 48,
    parameter int MODE_W      = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_word,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba,
    output logic [DATA_W/8-1:0] dqm,
    output logic              init_done
);

    localparam int DQM_W = DATA_W / 8;

    seq_state_t state;
    cmd_pins_t  pins;

    // Phase controller.
    sdinit_ctrl #(
        .STARTUP_CYC (STARTUP_CYC),
        .TRP_CYC     (TRP_CYC),
        .TRC_CYC     (TRC_CYC),
        .TMRD_CYC    (TMRD_CYC),
        .REF_COUNT   (REF_COUNT)
    ) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .state (state)
    );

    // Pin decoder.
    sdinit_pins #(
        .ADDR_W (ADDR_W),
        .BA_W   (BA_W),
        .DQM_W  (DQM_W),
        .MODE_W (MODE_W),
        .AP_BIT (10)
    ) u_pins (
        .state     (state),
        .mode_word (mode_word),
        .cke       (cke),
        .pins      (pins),
        .addr      (addr),
        .ba        (ba),
        .dqm       (dqm),
        .done      (init_done)
    );

    // Command pin fan-out.
    always_comb begin
        cs_n  = pins.cs_n;
        ras_n = pins.ras_n;
        cas_n = pins.cas_n;
        we_n  = pins.we_n;
    end

    // Once out of reset, enable and masks stay high.
    assert_pins_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (cke && (&dqm)));

    // Ready is sticky until reset.
    assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    // A mode load carries the mode word on bank 0.
    assert_mrs_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !ras_n && !cas_n && !we_n) |-> ((addr == ADDR_W'(mode_word)) && (ba == '0)));

endmodule

// File: tb/sdinit_seq_test.sv
`timescale 1ns/1ps
module sdinit_seq_test;

    localparam int B_START = 120;
    localparam int B_TRP   = 3;
    localparam int B_TRC   = 9;
    localparam int B_TMRD  = 2;
    localparam int B_REF   = 9;
    localparam int PALL_E  = 1 + B_START;
    localparam int REF0_E  = PALL_E + B_TRP;
    localparam int MRS_E   = REF0_E + B_REF * B_TRC;
    localparam int DONE_E  = MRS_E + B_TMRD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] mode_word = '0;
    logic        cke, cs_n, ras_n, cas_n, we_n, init_done;
    logic [11:0] addr;
    logic [1:0]  ba;
    logic [5:0]  dqm;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    sdinit_seq #(
        .STARTUP_CYC (B_START),
        .TRP_CYC     (B_TRP),
        .TRC_CYC     (B_TRC),
        .TMRD_CYC    (B_TMRD),
        .REF_COUNT   (B_REF)
    ) uut (
        .clk (clk), .rst_n (rst_n), .mode_word (mode_word),
        .cke (cke), .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
        .addr (addr), .ba (ba), .dqm (dqm), .init_done (init_done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Command decode: 0 NOP, 1 PALL, 2 REF, 3 MRS, 9 illegal.
    function automatic int dec_cmd(input logic cs, input logic r, input logic c, input logic w);
        if (cs) return 9;
        case ({r, c, w})
            3'b111: return 0;
            3'b010: return 1;
            3'b001: return 2;
            3'b000: return 3;
            default: return 9;
        endcase
    endfunction

    function automatic int ref_slot(input int k);
        return REF0_E + k * B_TRC;
    endfunction

    task automatic check_reset_state(input string tag);
        chk(cke == 1'b0 && cs_n == 1'b0 && dqm == 6'd0 && init_done == 1'b0,
            "R1", tag, {cke, cs_n, init_done, 6'(dqm)}, 0);
    endtask

    task automatic hold_reset(input int n);
        rst_n = 1'b0;
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // One init run; abort_at > 0 asserts reset after that sample.
    task automatic run_init(input logic [11:0] mw, input int abort_at, input bit after_abort);
        int cyc = 0, c;
        int pall_c = -1, first_ref = -1, ref_cnt = 0, gap_bad = 0;
        int mrs_c = -1, done_c = -1, done_drop = 0, pin_bad = 0, enc_bad = 0, extra = 0;
        logic a10 = 1'b0;
        logic [11:0] mrs_addr = '0;
        logic [1:0]  mrs_ba = '0;
        mode_word = mw;
        rst_n = 1'b1;
        while (1) begin
            @(negedge clk);
            cyc++;
            if (!cke || dqm != 6'h3F) pin_bad++;
            c = dec_cmd(cs_n, ras_n, cas_n, we_n);
            case (c)
                0: ;
                1: if (pall_c < 0) begin pall_c = cyc; a10 = addr[10]; end else extra++;
                2: begin
                    if (pall_c < 0) extra++;
                    if (ref_cnt == 0) first_ref = cyc;
                    if (cyc != ref_slot(ref_cnt)) gap_bad++;
                    ref_cnt++;
                end
                3: if (mrs_c < 0) begin mrs_c = cyc; mrs_addr = addr; mrs_ba = ba; end else extra++;
                default: enc_bad++;
            endcase
            if (init_done && done_c < 0) done_c = cyc;
            if (done_c >= 0 && !init_done) done_drop++;
            if (abort_at > 0 && cyc == abort_at) break;
            if (cyc >= DONE_E + 20 || cyc > 2000) break;
        end
        chk(pin_bad == 0, "R2", "cke/dqm high", pin_bad, 0);
        chk(enc_bad == 0 && extra == 0, "R8", "NOP between commands", enc_bad + extra, 0);
        if (abort_at > 0) begin
            hold_reset(2);
            check_reset_state("reset mid-sequence");
            hold_reset(1);
            return;
        end
        if (after_abort)
            chk(pall_c == PALL_E, "R9", "restart precharge cycle", pall_c, PALL_E);
        chk(pall_c == PALL_E, "R3", "precharge cycle", pall_c, PALL_E);
        chk(a10 == 1'b1, "R3", "precharge A10", int'(a10), 1);
        chk(first_ref == REF0_E, "R4", "first refresh cycle", first_ref, REF0_E);
        chk(ref_cnt == B_REF, "R5", "refresh count", ref_cnt, B_REF);
        chk(gap_bad == 0, "R5", "refresh spacing", gap_bad, 0);
        chk(mrs_c == MRS_E, "R6", "mode load cycle", mrs_c, MRS_E);
        chk(mrs_addr == mw && mrs_ba == 2'd0, "R6", "mode word on bus",
            int'({mrs_ba, mrs_addr}), int'({2'd0, mw}));
        chk(done_c == DONE_E, "R7", "done rise cycle", done_c, DONE_E);
        chk(done_drop == 0, "R7", "done sticky", done_drop, 0);
        hold_reset(2);
        check_reset_state("reset after done");
        hold_reset(1);
    endtask

    initial begin
        bit prev_abort;
        void'($urandom(32'h5EED));
        hold_reset(4);
        check_reset_state("initial reset");
        // Directed corners: extreme mode words, abort during refresh burst.
        run_init(12'h000, 0, 1'b0);
        run_init(12'hFFF, 0, 1'b0);
        run_init(12'h5A5, REF0_E + 2 * B_TRC + 1, 1'b0);
        run_init(12'h233, 0, 1'b1);
        run_init(12'h111, 1, 1'b0);
        prev_abort = 1'b1;
        // Random runs: random mode words, half cut short by reset.
        for (int i = 0; i < 12; i++) begin
            logic [11:0] mw;
            int ab;
            mw = 12'($urandom);
            ab = ($urandom % 2 == 0) ? int'(1 + ($urandom % (DONE_E + 10))) : 0;
            run_init(mw, ab, prev_abort);
            prev_abort = (ab > 0);
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule